// File: doc/BRIEF.md
# DMA Request/Acknowledge Channel Arbiter

This block is the request front end of a DMA engine. Each of its channels takes a level request from one peripheral. All request lines pass through a two-flop synchronizer. While no handshake is open, the block picks one enabled, pending channel by a programmable 2-bit priority. It then offers that channel to the bus-side engine as a single transfer command.

When the engine reports that the peripheral access has been done, the block raises the acknowledge for that peripheral. It holds the acknowledge until the synchronized request falls, which closes a four-phase handshake. Only after that does it arbitrate again. The channel count is a parameter: seven for the larger instance and five for the smaller one.

The transfer command is a valid/ready interface. `xfer_valid` rises with the selected channel on `xfer_ch`. Both hold unchanged until a cycle in which `xfer_ready` is high, and the engine takes the command on that edge. The engine then pulses `xfer_done` for one cycle, no earlier than the cycle after acceptance. The engine cannot stall the acknowledge side once it has reported done.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is asserted, and right after it is released, every acknowledge is low and `xfer_valid` is low.
- R2: A request that rises while the block is idle produces `xfer_valid` after exactly three rising clock edges. These are two synchronizer stages and one arbitration register.
- R3: Among eligible channels, the one with the highest priority code wins. Channel i's code is `ch_prio[2i+1:2i]`, with 3 the highest and 0 the lowest.
- R4: Among eligible channels of equal priority code, the lowest channel number wins.
- R5: A channel whose `ch_en` bit is 0 is never selected while its request stays pending, and it is served once enabled.
- R6: `xfer_valid` and `xfer_ch` hold steady until accepted with `xfer_ready`. A `xfer_done` pulse that arrives when no accepted transfer is waiting is ignored.
- R7: The acknowledge of the selected channel, and only that one, rises on the edge after the edge that sampled `xfer_done`.
- R8: Acknowledge stays high while the synchronized request is high. It falls three edges after the peripheral drops its request, even if the channel was disabled meanwhile.
- R9: No new selection is made while a handshake is open. A higher-priority request that arrives mid-handshake waits for it to complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_req | input | NUM_CH | Level requests from peripherals, asynchronous |
| ch_en | input | NUM_CH | Per-channel enable mask |
| ch_prio | input | 2*NUM_CH | Packed 2-bit priority code per channel |
| ch_ack | output | NUM_CH | Acknowledge to each peripheral, at most one high |
| xfer_valid | output | 1 | Transfer command offered to the bus side |
| xfer_ready | input | 1 | Bus side accepts the command |
| xfer_ch | output | $clog2(NUM_CH) | Channel index of the offered command |
| xfer_done | input | 1 | One-cycle pulse: peripheral access performed |

## Verification
A corrupted handshake state shows at the ports within one cycle. Examples are an acknowledge on the wrong line, an acknowledge with no done behind it, or a command offered while an acknowledge is still high. The per-cycle model flags any of these on the next falling edge.

A wrong selection in the priority picker shows only in `xfer_ch` at the moment a command is offered. The bench therefore compares the channel on every valid cycle and also checks whole grant orders after multi-channel bursts. A broken synchronizer depth moves the request-to-valid and drop-to-release latencies by a cycle, and the bench measures both exactly.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int PRIO_W = 2;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_ISSUE = 2'd1,
    HS_WAIT  = 2'd2,
    HS_ACK   = 2'd3
  } hs_state_e;
endpackage

// File: rtl/dma_arb_sync.sv
module dma_arb_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 7,
  localparam int IDXW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0]        eligible,
  input  logic [PRIO_W*NUM_CH-1:0] prio,
  output logic                     any,
  output logic [IDXW-1:0]          win
);
  logic [PRIO_W-1:0] best;
  logic              found;

  // Scan from the top channel down; ">=" lets a lower index take a tie.
  always_comb begin
    best  = '0;
    found = 1'b0;
    win   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (eligible[i] && (!found || prio[PRIO_W*i +: PRIO_W] >= best)) begin
        best  = prio[PRIO_W*i +: PRIO_W];
        win   = IDXW'(i);
        found = 1'b1;
      end
    end
    any = found;
  end

  always_comb begin
    AST_WIN_ELIGIBLE: assert (!(|eligible) || eligible[win]); // R5
  end
endmodule

// File: rtl/dma_arb_hs.sv
module dma_arb_hs
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 7,
  localparam int IDXW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any,
  input  logic [IDXW-1:0]   win,
  input  logic [NUM_CH-1:0] req_s,
  input  logic              xfer_ready,
  input  logic              xfer_done,
  output logic              xfer_valid,
  output logic [IDXW-1:0]   xfer_ch,
  output logic [NUM_CH-1:0] ch_ack
);
  hs_state_e       state;
  logic [IDXW-1:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= HS_IDLE;
      cur   <= '0;
    end else begin
      case (state)
        HS_IDLE:  if (any) begin
                    cur   <= win;
                    state <= HS_ISSUE;
                  end
        HS_ISSUE: if (xfer_ready) state <= HS_WAIT;
        HS_WAIT:  if (xfer_done)  state <= HS_ACK;
        HS_ACK:   if (!req_s[cur]) state <= HS_IDLE;
        default:  state <= HS_IDLE;
      endcase
    end
  end

  assign xfer_valid = (state == HS_ISSUE);
  assign xfer_ch    = cur;
  assign ch_ack     = (state == HS_ACK) ? (NUM_CH'(1) << cur) : '0;

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_ch)); // R6
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_ack)); // R7
  AST_ACK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HS_WAIT) && xfer_done |=> ch_ack != '0); // R7
  AST_ACK_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_ack != '0) |-> $past(xfer_done)); // R7
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_ack & req_s) != '0 |=> ch_ack == $past(ch_ack)); // R8
  AST_NO_GRANT_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ch_ack != '0 |-> !xfer_valid); // R9
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 7,
  localparam int IDXW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        ch_req,
  input  logic [NUM_CH-1:0]        ch_en,
  input  logic [PRIO_W*NUM_CH-1:0] ch_prio,
  output logic [NUM_CH-1:0]        ch_ack,
  output logic                     xfer_valid,
  input  logic                     xfer_ready,
  output logic [IDXW-1:0]          xfer_ch,
  input  logic                     xfer_done
);
  logic [NUM_CH-1:0] req_s;
  logic [NUM_CH-1:0] eligible;
  logic              any;
  logic [IDXW-1:0]   win;

  dma_arb_sync #(.W(NUM_CH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ch_req),
    .q     (req_s)
  );

  assign eligible = req_s & ch_en;

  dma_arb_pick #(.NUM_CH(NUM_CH)) u_pick (
    .eligible (eligible),
    .prio     (ch_prio),
    .any      (any),
    .win      (win)
  );

  dma_arb_hs #(.NUM_CH(NUM_CH)) u_hs (
    .clk        (clk),
    .rst_n      (rst_n),
    .any        (any),
    .win        (win),
    .req_s      (req_s),
    .xfer_ready (xfer_ready),
    .xfer_done  (xfer_done),
    .xfer_valid (xfer_valid),
    .xfer_ch    (xfer_ch),
    .ch_ack     (ch_ack)
  );
endmodule

// File: tb/tb_dma_req_arbiter.sv
`timescale 1ns/1ps
module tb_dma_req_arbiter;
  localparam int N  = 7;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  ch_req = '0;
  logic [N-1:0]  ch_en = '0;
  logic [2*N-1:0] ch_prio = '0;
  logic          xfer_ready = 1'b0;
  logic          xfer_done = 1'b0;
  logic [N-1:0]  ch_ack;
  logic          xfer_valid;
  logic [IW-1:0] xfer_ch;

  dma_req_arbiter #(.NUM_CH(N)) dut (
    .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_en(ch_en),
    .ch_prio(ch_prio), .ch_ack(ch_ack), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_ch(xfer_ch), .xfer_done(xfer_done)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int want[N], pst[N], rise_c[N], fall_c[N];
  int done_c = 0, cnt = 0, rdy_pat = 0;
  bit busy = 0, acc = 0, force_done = 0, meas_lat = 0;
  int glog[$];
  // reference model state
  int s1[N], s2[N];
  int ms = 0, mcur = 0;
  logic [N-1:0] pack = '0;
  logic         pvalid = 1'b0;

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // model and grant log: read pre-edge values
  always @(posedge clk) begin
    cyc++;
    acc = rst_n && xfer_valid && xfer_ready;
    if (acc) glog.push_back(int'(xfer_ch));
    if (!rst_n) begin
      ms = 0; mcur = 0;
      for (int i = 0; i < N; i++) begin s1[i] = 0; s2[i] = 0; end
    end else begin
      case (ms)
        0: begin
          int bw; int bp;
          bw = -1; bp = -1;
          for (int i = 0; i < N; i++)
            if (s2[i] != 0 && ch_en[i] && int'(ch_prio[2*i +: 2]) > bp) begin
              bw = i; bp = int'(ch_prio[2*i +: 2]);
            end
          if (bw >= 0) begin mcur = bw; ms = 1; end
        end
        1: if (xfer_ready) ms = 2;
        2: if (xfer_done) ms = 3;
        default: if (s2[mcur] == 0) ms = 0;
      endcase
      for (int i = 0; i < N; i++) begin s2[i] = s1[i]; s1[i] = int'(ch_req[i]); end
    end
  end

  // peripherals and bus-side engine
  always @(posedge clk) begin
    #1;
    xfer_done = 1'b0;
    if (force_done) begin xfer_done = 1'b1; force_done = 0; done_c = cyc; end
    if (busy) begin
      if (cnt == 0) begin xfer_done = 1'b1; busy = 0; done_c = cyc; end
      else cnt--;
    end
    if (acc) begin busy = 1; cnt = 1; end
    rdy_pat++;
    xfer_ready = (rdy_pat % 3) != 0;
    for (int i = 0; i < N; i++) begin
      case (pst[i])
        0: if (want[i] > 0) begin want[i]--; ch_req[i] = 1'b1; pst[i] = 1; rise_c[i] = cyc; end
        1: if (ch_ack[i]) begin ch_req[i] = 1'b0; pst[i] = 2; fall_c[i] = cyc; end
        default: if (!ch_ack[i]) pst[i] = 0;
      endcase
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [N-1:0] eack;
      eack = (ms == 3) ? (N'(1) << mcur) : '0;
      check(xfer_valid == (ms == 1), "R6 R9 xfer_valid", int'(xfer_valid), int'(ms == 1));
      check(ch_ack == eack, "R7 R8 ch_ack", int'(ch_ack), int'(eack));
      if (ms == 1) check(int'(xfer_ch) == mcur, "R3 R4 xfer_ch", int'(xfer_ch), mcur);
      if (ch_ack != '0 && pack == '0)
        check(cyc - done_c == 1, "R7 done-to-ack cycles", cyc - done_c, 1);
      if (ch_ack == '0 && pack != '0)
        for (int i = 0; i < N; i++)
          if (pack[i]) check(cyc - fall_c[i] == 3, "R8 release latency", cyc - fall_c[i], 3);
      if (meas_lat && xfer_valid && !pvalid)
        check(cyc - rise_c[xfer_ch] == 3, "R2 request-to-valid", cyc - rise_c[xfer_ch], 3);
    end
    pack = ch_ack;
    pvalid = xfer_valid;
  end

  task automatic wait_idle();
    int quiet = 0;
    for (int k = 0; k < 3000; k++) begin
      bit idle = (ms == 0);
      @(negedge clk);
      for (int i = 0; i < N; i++) if (want[i] != 0 || pst[i] != 0) idle = 0;
      quiet = idle ? quiet + 1 : 0;
      if (quiet >= 6) return;
    end
    check(0, "R9 drain timeout", 0, 1);
  endtask

  task automatic check_order(int exp[$], string tag);
    check(glog.size() == exp.size(), tag, glog.size(), exp.size());
    for (int i = 0; i < exp.size() && i < glog.size(); i++)
      check(glog[i] == exp[i], tag, glog[i], exp[i]);
  endtask

  task automatic set_prio(int c, int p);
    ch_prio[2*c +: 2] = 2'(p);
  endtask

  task automatic run();
    repeat (2) @(negedge clk);
    check(ch_ack == '0, "R1 ack in reset", int'(ch_ack), 0);
    check(!xfer_valid, "R1 valid in reset", int'(xfer_valid), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    check(ch_ack == '0 && !xfer_valid, "R1 after reset", int'(ch_ack), 0);
    ch_en = '1;
    set_prio(0, 0); set_prio(1, 2); set_prio(2, 3); set_prio(3, 2);
    set_prio(4, 3); set_prio(5, 1); set_prio(6, 0);

    // single request: latency and release timing
    meas_lat = 1; glog.delete(); want[3] = 1;
    wait_idle(); meas_lat = 0;
    check_order('{3}, "R2 single grant");

    // all at once: priority then lowest index
    glog.delete();
    for (int i = 0; i < N; i++) want[i] = 1;
    wait_idle();
    check_order('{2, 4, 1, 3, 5, 0, 6}, "R3 R4 burst order");

    // masked channels stay pending
    glog.delete(); ch_en = 7'b1011011;
    for (int i = 0; i < N; i++) want[i] = 1;
    for (int k = 0; k < 2000 && glog.size() < 5; k++) @(negedge clk);
    repeat (40) @(negedge clk);
    check_order('{4, 1, 3, 0, 6}, "R5 masked order");
    check(ch_req[2] && ch_req[5] && ch_ack == '0, "R5 masked still pending", int'(ch_req), 7'h24);
    ch_en = '1;
    wait_idle();
    check_order('{4, 1, 3, 0, 6, 2, 5}, "R5 served after enable");

    // stray done while idle
    @(negedge clk); force_done = 1;
    repeat (3) @(negedge clk);
    check(ch_ack == '0 && !xfer_valid, "R6 stray done ignored", int'(ch_ack), 0);

    // higher priority arriving mid-handshake waits
    glog.delete(); want[6] = 1;
    for (int k = 0; k < 100 && !xfer_valid; k++) @(negedge clk);
    want[4] = 1;
    wait_idle();
    check_order('{6, 4}, "R9 no preemption");

    // disable during acknowledge
    want[0] = 1;
    for (int k = 0; k < 100 && !ch_ack[0]; k++) @(negedge clk);
    check(ch_ack[0], "R8 ack reached", int'(ch_ack), 1);
    ch_en[0] = 1'b0;
    for (int k = 0; k < 8 && ch_ack[0]; k++) @(negedge clk);
    check(!ch_ack[0], "R8 ack drops when disabled", int'(ch_ack), 0);
    ch_en[0] = 1'b1;
    wait_idle();
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      want[i] = 0; pst[i] = 0; rise_c[i] = 0; fall_c[i] = 0; s1[i] = 0; s2[i] = 0;
    end
    fork
      run();
      begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule